// File: doc/BRIEF.md
# Remapped Vector Element Loop Sequencer

This block walks the element loop of one vector operation and, for every element it visits, emits a tuple of element offsets for five operand slots: three sources (A, B, C), a primary destination and a secondary slot that serves either as a second destination or as an address offset. A slot either follows the running element number directly or sends it through one of four shared shape remappers. A 2-bit selector picks the remapper for each slot, and an enable bit per slot turns the remapping on. Each shape folds the running number into a 2D grid, can read that grid transposed, and then adds a fixed offset. Because the offsets are computed independently for every slot, an operation that is predicated on both its source and its destination side still receives two independent remapped offsets.

A start pulse launches a run from a resume index, which can be nonzero when an interrupted operation is restarted. The loop covers elements from that index up to VL-1. When the sub-vector length is greater than one, each element expands into 2 to 4 sub-elements. These are remapped as part of the flat sequence `id = elem*SUBVL + sub`, while the predicate bit still applies to the whole element. The outgoing tuple carries the current element number, so control logic can save it for a later resume. A scalar destination cuts the loop short after the first element group. Tuples leave through a valid/ready handshake, and a one-cycle `done` pulse ends each run.

The configuration inputs (`vl`, `resume_idx`, `subvl_m1`, `pred`, `vec_mask`, `remap_en`, `remap_sel` and the shape fields) must be held stable from the start pulse until `done`.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are low.
- R2: For a vector slot with its enable bit clear, the offset equals `id = elem*SUBVL + sub`, where SUBVL = `subvl_m1`+1. Tuples come out in order: `sub` runs from 0 to SUBVL-1 inside each `elem`, and `elem` runs upward. Slot k occupies bits [7k+6:7k] of `out_offs` and is controlled by `vec_mask[k]` and `remap_en[k]`. Slots 0 to 4 are source A, source B, source C, destination and secondary.
- R3: For a vector slot with its enable bit set, the remapper s = `remap_sel[2k+1:2k]` is used. With xd = xm1+1, yd = ym1+1, n = id mod (xd*yd), x = n mod xd and y = n / xd, the offset is (transpose ? x*yd+y : n) + off, modulo 128. Shape s takes its fields from `shp_xm1[3s+2:3s]`, `shp_ym1[3s+2:3s]`, `shp_tr[s]` and `shp_off[7s+6:7s]`.
- R4: A slot whose `vec_mask` bit is 0 (scalar) always carries offset 0.
- R5: `out_exec` equals `pred[elem]` for every sub-element of that element. A cleared predicate bit still emits the tuple, and the loop still advances.
- R6: When `vec_mask[3]` is 0 (scalar destination), only the SUBVL tuples of the first element are emitted.
- R7: The first tuple of a run has `elem` equal to `resume_idx`.
- R8: `done` is high for one cycle, in the cycle after the last accepted tuple. If `resume_idx >= vl`, no tuple is emitted and `done` is high in the cycle after the start pulse.
- R9: While `out_valid` is high and `out_ready` is low, the tuple is held unchanged.
- R10: `out_elem` reports the element number of the tuple currently presented, so it can be saved for a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, taken only while idle |
| vl | input | 5 | Vector length, 0 to 16 |
| resume_idx | input | 5 | First element number of the run |
| subvl_m1 | input | 2 | Sub-vector length minus one |
| pred | input | 16 | Predicate, one bit per element |
| vec_mask | input | 5 | Per-slot vector flag (1 = vector) |
| remap_en | input | 5 | Per-slot remap enable |
| remap_sel | input | 10 | Per-slot shape selector, 2 bits each |
| shp_xm1 | input | 12 | Per-shape x dimension minus one |
| shp_ym1 | input | 12 | Per-shape y dimension minus one |
| shp_tr | input | 4 | Per-shape transpose flag |
| shp_off | input | 28 | Per-shape added offset |
| out_ready | input | 1 | Consumer accepts the tuple |
| out_valid | output | 1 | Tuple present |
| out_elem | output | 5 | Current element number |
| out_sub | output | 2 | Current sub-element number |
| out_exec | output | 1 | Predicate bit of the current element |
| out_offs | output | 35 | Five 7-bit slot offsets |
| done | output | 1 | End-of-run pulse |

## Verification
The first tuple is presented in the cycle after the start pulse. Each accepted tuple is replaced by the next one in the cycle after its acceptance. `done` rises in the cycle after the final acceptance, or in the cycle after the start pulse when the run is empty. The bench drives inputs and `out_ready` on the falling edge and samples shortly afterwards, so an accepted tuple is compared against the next expected tuple from an arithmetic model. The completion pulse is checked to arrive exactly one sample after the last acceptance. Stall cycles are checked by comparing the held tuple on the following sample.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int NOPS = 5;
  localparam int NSH  = 4;
  localparam int SELW = 2;
  typedef enum logic [2:0] {
    SLOT_SRC_A = 3'd0,
    SLOT_SRC_B = 3'd1,
    SLOT_SRC_C = 3'd2,
    SLOT_DST   = 3'd3,
    SLOT_AUX   = 3'd4
  } slot_e;
endpackage

// File: rtl/vseq_shape.sv
module vseq_shape #(
  parameter int IDW  = 7,
  parameter int DIMW = 3
) (
  input  logic [IDW-1:0]  id,
  input  logic [DIMW-1:0] xm1,
  input  logic [DIMW-1:0] ym1,
  input  logic            tr,
  input  logic [IDW-1:0]  off,
  output logic [IDW-1:0]  idx
);
  localparam int CW = IDW + 2*DIMW + 2;
  logic [CW-1:0] xd, yd, area, n, x, y, tmap, sum;

  always_comb begin
    xd   = CW'(xm1) + CW'(1);
    yd   = CW'(ym1) + CW'(1);
    area = xd * yd;
    n    = CW'(id) % area;
    x    = n % xd;
    y    = n / xd;
    tmap = tr ? (x * yd + y) : n;
    sum  = tmap + CW'(off);
    idx  = sum[IDW-1:0];
  end
endmodule

// File: rtl/vseq_operand.sv
module vseq_operand #(
  parameter int IDW = 7,
  parameter int NSH = 4
) (
  input  logic [IDW-1:0]     id,
  input  logic               is_vec,
  input  logic               en,
  input  logic [1:0]         sel,
  input  logic [NSH*IDW-1:0] shape_idx,
  output logic [IDW-1:0]     offs
);
  always_comb begin
    if (!is_vec)  offs = '0;
    else if (en)  offs = shape_idx[sel*IDW +: IDW];
    else          offs = id;
  end
endmodule

// File: rtl/vseq_counter.sv
module vseq_counter #(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] vl,
  input  logic [IW-1:0] resume_idx,
  input  logic [1:0]    subvl_m1,
  input  logic          dst_vec,
  input  logic          ready,
  output logic          valid,
  output logic [IW-1:0] elem,
  output logic [1:0]    sub,
  output logic          done
);
  logic          busy_q, busy_d, done_q, done_d;
  logic [IW-1:0] elem_q, elem_d;
  logic [1:0]    sub_q, sub_d;
  logic          last_sub, last_elem, empty;

  assign last_sub  = (sub_q == subvl_m1);
  assign last_elem = ((elem_q + IW'(1)) == vl);
  assign empty     = (resume_idx >= vl);

  always_comb begin
    busy_d = busy_q;
    elem_d = elem_q;
    sub_d  = sub_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        if (empty) begin
          done_d = 1'b1;
        end else begin
          busy_d = 1'b1;
          elem_d = resume_idx;
          sub_d  = 2'd0;
        end
      end
    end else if (ready) begin
      if (!last_sub) begin
        sub_d = sub_q + 2'd1;
      end else if (last_elem || !dst_vec) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        elem_d = elem_q + IW'(1);
        sub_d  = 2'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      elem_q <= '0;
      sub_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      elem_q <= elem_d;
      sub_q  <= sub_d;
    end
  end

  assign valid = busy_q;
  assign elem  = elem_q;
  assign sub   = sub_q;
  assign done  = done_q;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int MAXVL = 16,
  parameter int DIMW  = 3,
  localparam int IW   = $clog2(MAXVL + 1),
  localparam int IDW  = IW + 2,
  localparam int PIW  = $clog2(MAXVL),
  localparam int NOPS = vseq_pkg::NOPS,
  localparam int NSH  = vseq_pkg::NSH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [IW-1:0]       vl,
  input  logic [IW-1:0]       resume_idx,
  input  logic [1:0]          subvl_m1,
  input  logic [MAXVL-1:0]    pred,
  input  logic [NOPS-1:0]     vec_mask,
  input  logic [NOPS-1:0]     remap_en,
  input  logic [2*NOPS-1:0]   remap_sel,
  input  logic [NSH*DIMW-1:0] shp_xm1,
  input  logic [NSH*DIMW-1:0] shp_ym1,
  input  logic [NSH-1:0]      shp_tr,
  input  logic [NSH*IDW-1:0]  shp_off,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [IW-1:0]       out_elem,
  output logic [1:0]          out_sub,
  output logic                out_exec,
  output logic [NOPS*IDW-1:0] out_offs,
  output logic                done
);
  logic [IDW-1:0]     id;
  logic [2:0]         sub_len;
  logic [NSH*IDW-1:0] shape_idx;

  vseq_counter #(.IW(IW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .resume_idx(resume_idx), .subvl_m1(subvl_m1),
    .dst_vec(vec_mask[vseq_pkg::SLOT_DST]), .ready(out_ready),
    .valid(out_valid), .elem(out_elem), .sub(out_sub), .done(done)
  );

  assign sub_len  = {1'b0, subvl_m1} + 3'd1;
  assign id       = IDW'(out_elem) * IDW'(sub_len) + IDW'(out_sub);
  assign out_exec = pred[out_elem[PIW-1:0]];

  for (genvar s = 0; s < NSH; s++) begin : g_shape
    vseq_shape #(.IDW(IDW), .DIMW(DIMW)) u_shape (
      .id(id),
      .xm1(shp_xm1[s*DIMW +: DIMW]),
      .ym1(shp_ym1[s*DIMW +: DIMW]),
      .tr(shp_tr[s]),
      .off(shp_off[s*IDW +: IDW]),
      .idx(shape_idx[s*IDW +: IDW])
    );
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_slot
    vseq_operand #(.IDW(IDW), .NSH(NSH)) u_op (
      .id(id),
      .is_vec(vec_mask[k]),
      .en(remap_en[k]),
      .sel(remap_sel[2*k +: 2]),
      .shape_idx(shape_idx),
      .offs(out_offs[k*IDW +: IDW])
    );
  end
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int MAXVL = 16,
  localparam int IW   = $clog2(MAXVL + 1),
  localparam int IDW  = IW + 2,
  localparam int NOPS = vseq_pkg::NOPS
) (
  input logic                clk,
  input logic                rst_n,
  input logic [IW-1:0]       vl,
  input logic [IW-1:0]       resume_idx,
  input logic [1:0]          subvl_m1,
  input logic [NOPS-1:0]     vec_mask,
  input logic                out_ready,
  input logic                out_valid,
  input logic [IW-1:0]       out_elem,
  input logic [1:0]          out_sub,
  input logic                out_exec,
  input logic [NOPS*IDW-1:0] out_offs,
  input logic                done
);
  logic [NOPS-1:0] zero_ok;
  always_comb begin
    for (int k = 0; k < NOPS; k++)
      zero_ok[k] = vec_mask[k] || (out_offs[k*IDW +: IDW] == '0);
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offs) &&
                               $stable(out_elem) && $stable(out_sub));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_scalar_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> &zero_ok);

  assert_elem_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_elem < vl) && (out_elem >= resume_idx));

  assert_group_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_sub != subvl_m1) |=>
      out_valid && (out_elem == $past(out_elem)) && (out_exec == $past(out_exec)));

  assert_scalar_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !vec_mask[3] |-> out_elem == resume_idx);
endmodule

bind vec_elem_seq vseq_chk #(.MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .vl(vl), .resume_idx(resume_idx),
  .subvl_m1(subvl_m1), .vec_mask(vec_mask), .out_ready(out_ready),
  .out_valid(out_valid), .out_elem(out_elem), .out_sub(out_sub),
  .out_exec(out_exec), .out_offs(out_offs), .done(done)
);

// File: tb/sim_vec_elem_seq.sv
`timescale 1ns/1ps
module sim_vec_elem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  vl = '0, resume_idx = '0;
  logic [1:0]  subvl_m1 = '0;
  logic [15:0] pred = '0;
  logic [4:0]  vec_mask = '0, remap_en = '0;
  logic [9:0]  remap_sel = '0;
  logic [11:0] shp_xm1 = '0, shp_ym1 = '0;
  logic [3:0]  shp_tr = '0;
  logic [27:0] shp_off = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_exec, done;
  logic [4:0]  out_elem;
  logic [1:0]  out_sub;
  logic [34:0] out_offs;

  int checks = 0, fails = 0, cyc = 0;
  bit wd_hit = 1'b0;

  vec_elem_seq u0 (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int shape_of(input int s, input int id);
    int xd, yd, n, x, y, t;
    xd = int'(shp_xm1[3*s +: 3]) + 1;
    yd = int'(shp_ym1[3*s +: 3]) + 1;
    n  = id % (xd * yd);
    x  = n % xd;
    y  = n / xd;
    t  = shp_tr[s] ? x * yd + y : n;
    return (t + int'(shp_off[7*s +: 7])) % 128;
  endfunction

  function automatic int exp_off(input int k, input int id);
    if (!vec_mask[k]) return 0;
    if (remap_en[k]) return shape_of(int'(remap_sel[2*k +: 2]), id);
    return id % 128;
  endfunction

  task automatic run_case(input int bp);
    int S, total, k, last_x, got_done;
    int hold_e, hold_s, hold_o;
    bit holding;
    S = int'(subvl_m1) + 1;
    if (resume_idx >= vl) total = 0;
    else if (!vec_mask[3]) total = S;
    else total = (int'(vl) - int'(resume_idx)) * S;
    k = 0; last_x = -1; got_done = 0; holding = 1'b0;
    hold_e = 0; hold_s = 0; hold_o = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 400 && !got_done; c++) begin
      out_ready = (bp == 0) ? 1'b1 : ((c % 3) != 1);
      #1;
      if (holding) begin
        chk("R9 held tuple", int'(out_offs[6:0]) + 128*int'(out_elem) + 4096*int'(out_sub),
            hold_o + 128*hold_e + 4096*hold_s);
        holding = 1'b0;
      end
      if (done) begin
        got_done = 1;
        chk("R8 done timing", c, (total == 0) ? 0 : last_x + 1);
        chk(vec_mask[3] ? "R2 tuple count" : "R6 tuple count", k, total);
        chk("R8 valid low at done", int'(out_valid), 0);
      end else if (out_valid) begin
        int e, j, id;
        e  = int'(resume_idx) + k / S;
        j  = k % S;
        id = e * S + j;
        chk((k == 0) ? "R7 first element" : "R10 element", int'(out_elem), e);
        chk("R2 sub order", int'(out_sub), j);
        chk("R5 exec", int'(out_exec), int'(pred[e % 16]));
        for (int s = 0; s < 5; s++)
          chk(!vec_mask[s] ? "R4 scalar slot" : (remap_en[s] ? "R3 remap slot" : "R2 linear slot"),
              int'(out_offs[7*s +: 7]), exp_off(s, id));
        if (out_ready) begin
          k++;
          last_x = c;
        end else begin
          holding = 1'b1;
          hold_e = int'(out_elem); hold_s = int'(out_sub); hold_o = int'(out_offs[6:0]);
        end
      end
      @(negedge clk);
    end
    chk("R8 done seen", got_done, 1);
    out_ready = 1'b0;
  endtask

  initial begin
    shp_xm1 = {3'd1, 3'd2, 3'd3, 3'd3};
    shp_ym1 = {3'd3, 3'd1, 3'd0, 3'd3};
    shp_tr  = 4'b0101;
    shp_off = {7'd9, 7'd0, 7'd5, 7'd0};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // linear, all vector, alternating predicate
    vl = 5'd8; resume_idx = '0; subvl_m1 = 2'd0; pred = 16'h5555;
    vec_mask = 5'b11111; remap_en = '0; remap_sel = '0;
    run_case(0);
    // all slots remapped through different shapes, backpressure
    vl = 5'd16; pred = 16'hA3C1; remap_en = 5'b11111;
    remap_sel = {2'd3, 2'd2, 2'd1, 2'd0, 2'd2};
    run_case(1);
    // sub-vector expansion with mixed remap
    vl = 5'd5; subvl_m1 = 2'd2; remap_en = 5'b10101; pred = 16'h0012;
    run_case(1);
    // scalar sources
    vec_mask = 5'b01010; subvl_m1 = 2'd1;
    run_case(0);
    // scalar destination early exit
    vec_mask = 5'b10111; vl = 5'd10; resume_idx = 5'd3;
    run_case(1);
    // resume mid-vector
    vec_mask = 5'b11111; vl = 5'd9; resume_idx = 5'd6; subvl_m1 = 2'd3;
    run_case(0);
    // empty runs
    resume_idx = 5'd9;
    run_case(0);
    vl = 5'd0; resume_idx = 5'd0;
    run_case(1);
    // sweep
    for (int sv = 0; sv < 4; sv++)
      for (int v = 1; v <= 16; v += 5)
        for (int r = 0; r < 2; r++) begin
          subvl_m1 = 2'(sv); vl = 5'(v); resume_idx = (r == 0) ? 5'd0 : 5'(v - 1);
          remap_en = 5'(v * 7 + sv); remap_sel = 10'(v * 37 + sv * 5);
          vec_mask = (sv == 3 && r == 1) ? 5'b10111 : 5'b11111;
          pred = 16'(v * 1234 + sv);
          run_case(sv % 2);
        end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule